// File: doc/BRIEF.md
# Cascadable Up/Down Binary Counter Stage

This block is a synchronous binary counter slice, four bits wide by default. On each rising clock edge it does one of four things. It can load a parallel value, step up, step down, or keep its value. Stepping wraps around the full binary range in both directions. Counting needs two active-low enables to be low at once. The first is a broadcast enable that is shared by every stage. The second is a chain enable that comes from the stage below.

An active-low terminal flag is formed combinationally from three things: the chain enable, the direction, and the present count. The flag is low only when the chain enable is low and the count is at the end of the range for the selected direction. The end of the range is all ones when counting up and all zeros when counting down. To build a longer counter, connect each stage's flag to the next stage's chain enable. All stages then step together on the same edge, with no extra latency per stage.

Internally, a decoder turns the control inputs into one of four named operations. The operations are `OP_LOAD`, `OP_UP`, `OP_DOWN` and `OP_HOLD`. A `unique case` on that operation selects the next count. There are only two transitions of the state register. An asynchronous reset returns it to zero. On every clock edge it moves to the value that the decoded operation selects.

Top module: `updn_cnt_top`

## Requirements
- R1: While `rst_n` is low the count is 0, whatever the clock does.
- R2: If `load_n` is low at a rising edge, `q` takes the value of `din` on that edge, whatever `up_dn`, `cnt_en_n` and `chain_en_n` are.
- R3: The count changes on a rising edge, other than by a load, only when `load_n` is high and both `cnt_en_n` and `chain_en_n` are low.
- R4: With counting enabled and `up_dn` = 1, `q` increases by one, and the maximum value wraps to 0. Loading 12 and counting gives 13, 14, 15, 0, 1, 2.
- R5: With counting enabled and `up_dn` = 0, `q` decreases by one, and 0 wraps to the maximum value.
- R6: If `load_n` is high and either count enable is high, `q` keeps its value.
- R7: `tc_n` is 0 exactly when `chain_en_n` is 0 and either `up_dn` = 1 with `q` all ones, or `up_dn` = 0 with `q` all zeros. Otherwise `tc_n` is 1. It has no register delay.
- R8: If `up_dn` changes while `q` sits at all ones or all zeros, `tc_n` follows the new direction in the same cycle.
- R9: Two stages connected from `tc_n` to `chain_en_n` act as one 8-bit counter. This includes the wrap from 255 to 0 and from 0 to 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| up_dn | input | 1 | 1 = count up, 0 = count down |
| load_n | input | 1 | Parallel load, active low |
| cnt_en_n | input | 1 | Broadcast count enable, active low |
| chain_en_n | input | 1 | Chain count enable, active low; also gates `tc_n` |
| din | input | WIDTH | Parallel load value |
| q | output | WIDTH | Present count |
| tc_n | output | 1 | Terminal flag, active low |

## Verification
A wrong count register appears on `q` one edge after the faulty step. It also appears on `tc_n` in that same cycle whenever the bad value is a terminal value. A fault in the direction or enable decode appears on the first counting edge: `q` moves by the wrong amount or does not move at all. In a cascade, a wrong terminal flag shows up as an early or missing step in the upper stage. This is seen at the next low-stage wrap, no more than 16 edges later.

// File: rtl/updn_cnt_pkg.sv
package updn_cnt_pkg;
    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_LOAD = 2'd1,
        OP_UP   = 2'd2,
        OP_DOWN = 2'd3
    } cnt_op_e;
endpackage

// File: rtl/updn_cnt_decode.sv
module updn_cnt_decode
    import updn_cnt_pkg::*;
(
    input  logic    load_n,
    input  logic    cnt_en_n,
    input  logic    chain_en_n,
    input  logic    up_dn,
    output cnt_op_e op
);
    logic counting;

    assign counting = ~cnt_en_n & ~chain_en_n;

    // Load has priority over every other control.
    always_comb begin
        if (!load_n)       op = OP_LOAD;
        else if (!counting) op = OP_HOLD;
        else if (up_dn)    op = OP_UP;
        else               op = OP_DOWN;
    end
endmodule

// File: rtl/updn_cnt_next.sv
module updn_cnt_next
    import updn_cnt_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  cnt_op_e          op,
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] nxt
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    always_comb begin
        unique case (op)
            OP_LOAD: nxt = din;
            OP_UP:   nxt = cur + ONE;
            OP_DOWN: nxt = cur - ONE;
            OP_HOLD: nxt = cur;
            default: nxt = cur;
        endcase
    end
endmodule

// File: rtl/updn_cnt_term.sv
module updn_cnt_term #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] cur,
    input  logic             up_dn,
    input  logic             chain_en_n,
    output logic             tc_n
);
    logic [WIDTH-1:0] all_one;
    logic [WIDTH-1:0] all_zero;

    // Per-bit terminal match chains.
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (i == 0) begin : g_first
            assign all_one[i]  = cur[i];
            assign all_zero[i] = ~cur[i];
        end else begin : g_rest
            assign all_one[i]  = all_one[i-1] & cur[i];
            assign all_zero[i] = all_zero[i-1] & ~cur[i];
        end
    end

    logic at_end;
    assign at_end = up_dn ? all_one[WIDTH-1] : all_zero[WIDTH-1];
    assign tc_n   = ~(at_end & ~chain_en_n);
endmodule

// File: rtl/updn_cnt_top.sv
module updn_cnt_top
    import updn_cnt_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             up_dn,
    input  logic             load_n,
    input  logic             cnt_en_n,
    input  logic             chain_en_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] q,
    output logic             tc_n
);
    cnt_op_e          op;
    logic [WIDTH-1:0] cnt_q;
    logic [WIDTH-1:0] cnt_d;

    updn_cnt_decode u_dec (
        .load_n     (load_n),
        .cnt_en_n   (cnt_en_n),
        .chain_en_n (chain_en_n),
        .up_dn      (up_dn),
        .op         (op)
    );

    updn_cnt_next #(.WIDTH(WIDTH)) u_next (
        .op  (op),
        .cur (cnt_q),
        .din (din),
        .nxt (cnt_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    updn_cnt_term #(.WIDTH(WIDTH)) u_term (
        .cur        (cnt_q),
        .up_dn      (up_dn),
        .chain_en_n (chain_en_n),
        .tc_n       (tc_n)
    );

    assign q = cnt_q;
endmodule

// File: rtl/updn_cnt_chk.sv
module updn_cnt_chk #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             up_dn,
    input logic             load_n,
    input logic             cnt_en_n,
    input logic             chain_en_n,
    input logic [WIDTH-1:0] din,
    input logic [WIDTH-1:0] q,
    input logic             tc_n
);
    AST_RESET_ZERO: assert property (@(posedge clk) !rst_n |-> q == '0); // R1
    AST_LOAD_TAKES_DIN: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n |=> q == $past(din)); // R2
    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && (cnt_en_n || chain_en_n)) |=> $stable(q)); // R6
    AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !cnt_en_n && !chain_en_n && up_dn) |=> q == WIDTH'($past(q) + 1'b1)); // R4
    AST_DOWN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !cnt_en_n && !chain_en_n && !up_dn) |=> q == WIDTH'($past(q) - 1'b1)); // R5
    AST_TC_NEEDS_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
        !tc_n |-> !chain_en_n); // R7
    AST_TC_UP_END: assert property (@(posedge clk) disable iff (!rst_n)
        (!tc_n && up_dn) |-> (&q)); // R7
    AST_TC_DOWN_END: assert property (@(posedge clk) disable iff (!rst_n)
        (!tc_n && !up_dn) |-> (q == '0)); // R7
endmodule

bind updn_cnt_top updn_cnt_chk #(.WIDTH(WIDTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .up_dn      (up_dn),
    .load_n     (load_n),
    .cnt_en_n   (cnt_en_n),
    .chain_en_n (chain_en_n),
    .din        (din),
    .q          (q),
    .tc_n       (tc_n)
);

// File: tb/tb_updn_cnt_top.sv
module tb_updn_cnt_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       up_dn = 1'b1;
    logic       load_n = 1'b1;
    logic       cnt_en_n = 1'b1;
    logic       chain0_n = 1'b1;
    logic [7:0] din8 = '0;
    logic [3:0] q_lo, q_hi;
    logic       tc_lo_n, tc_hi_n;

    int checks = 0;
    int errors = 0;
    logic [7:0] model = '0;

    always #2 clk = ~clk;

    updn_cnt_top #(.WIDTH(4)) dut (
        .clk(clk), .rst_n(rst_n), .up_dn(up_dn), .load_n(load_n),
        .cnt_en_n(cnt_en_n), .chain_en_n(chain0_n), .din(din8[3:0]),
        .q(q_lo), .tc_n(tc_lo_n)
    );

    updn_cnt_top #(.WIDTH(4)) dut_hi (
        .clk(clk), .rst_n(rst_n), .up_dn(up_dn), .load_n(load_n),
        .cnt_en_n(cnt_en_n), .chain_en_n(tc_lo_n), .din(din8[7:4]),
        .q(q_hi), .tc_n(tc_hi_n)
    );

    function automatic logic exp_tc(logic [3:0] v, logic up, logic ch_n);
        return !(!ch_n && (up ? (v == 4'hF) : (v == 4'h0)));
    endfunction

    function automatic logic [7:0] exp_next(logic [7:0] v, logic ld_n, logic ce_n,
                                            logic ch_n, logic up, logic [7:0] d);
        if (!ld_n) return d;
        if (ce_n || ch_n) return v;
        return up ? v + 8'd1 : v - 8'd1;
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_tc(string tag);
        logic e_lo;
        e_lo = exp_tc(model[3:0], up_dn, chain0_n);
        check({tag, " R7 tc_lo"}, tc_lo_n, e_lo);
        check({tag, " R7 tc_hi"}, tc_hi_n, exp_tc(model[7:4], up_dn, e_lo));
    endtask

    task automatic cyc(logic ld_n, logic ce_n, logic ch_n, logic up, logic [7:0] d);
        string tag;
        @(negedge clk);
        load_n = ld_n; cnt_en_n = ce_n; chain0_n = ch_n; up_dn = up; din8 = d;
        #1;
        check_tc("cyc");
        if (!ld_n) tag = "R2";
        else if (ce_n || ch_n) tag = "R3 R6";
        else tag = up ? "R4" : "R5";
        @(posedge clk);
        model = exp_next(model, ld_n, ce_n, ch_n, up, d);
        #1;
        check({tag, " q_lo"}, q_lo, model[3:0]);
        check({"R9 ", tag, " q_hi"}, q_hi, model[7:4]);
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        // R1: reset state; edges while in reset do not move the count
        repeat (3) @(posedge clk);
        @(negedge clk);
        cnt_en_n = 1'b0; chain0_n = 1'b0; up_dn = 1'b0;
        @(posedge clk); #1;
        check("R1 q_lo", q_lo, 0);
        check("R1 q_hi", q_hi, 0);
        check_tc("R1");
        @(negedge clk);
        cnt_en_n = 1'b1; chain0_n = 1'b1; up_dn = 1'b1;
        rst_n = 1'b1;

        // R2: load ignores enables and direction
        cyc(1'b0, 1'b1, 1'b1, 1'b0, 8'hA5);
        cyc(1'b0, 1'b0, 1'b0, 1'b1, 8'h3C);

        // R4 sequence: load 12, count 13,14,15,0,1,2, then inhibit
        cyc(1'b0, 1'b1, 1'b1, 1'b1, 8'h0C);
        for (int i = 0; i < 6; i++) cyc(1'b1, 1'b0, 1'b0, 1'b1, 8'h00);
        check("R4 sequence end", q_lo, 2);
        cyc(1'b1, 1'b1, 1'b0, 1'b1, 8'h00);
        cyc(1'b1, 1'b0, 1'b1, 1'b1, 8'h00);
        check("R6 inhibit", q_lo, 2);

        // R8: direction flips at terminal values
        cyc(1'b0, 1'b1, 1'b0, 1'b1, 8'h0F);
        @(negedge clk); load_n = 1'b1; cnt_en_n = 1'b1; chain0_n = 1'b0; up_dn = 1'b1; #1;
        check("R8 up at 15", tc_lo_n, 0);
        up_dn = 1'b0; #1;
        check("R8 down at 15", tc_lo_n, 1);
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 8'h00);
        @(negedge clk); load_n = 1'b1; up_dn = 1'b0; #1;
        check("R8 down at 0", tc_lo_n, 0);
        up_dn = 1'b1; #1;
        check("R8 up at 0", tc_lo_n, 1);

        // R9: 8-bit wraps through the cascade
        cyc(1'b0, 1'b1, 1'b1, 1'b1, 8'hFF);
        cyc(1'b1, 1'b0, 1'b0, 1'b1, 8'h00);
        check("R9 wrap up", {q_hi, q_lo}, 0);
        cyc(1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
        check("R9 wrap down", {q_hi, q_lo}, 255);
        for (int i = 0; i < 40; i++) cyc(1'b1, 1'b0, 1'b0, 1'b1, 8'h00);
        for (int i = 0; i < 40; i++) cyc(1'b1, 1'b0, 1'b0, 1'b0, 8'h00);

        // Constrained random mix, biased toward counting
        for (int i = 0; i < 600; i++) begin
            logic [7:0] r;
            r = 8'($urandom);
            cyc(($urandom % 16) != 0, ($urandom % 5) == 0, ($urandom % 5) == 0,
                (i / 100) % 2 == 0 ? (($urandom % 8) != 0) : (($urandom % 8) == 0), r);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule